// File: doc/BRIEF.md
# Double-Buffered Blanking Packet Store

This block keeps up to fifteen generic info packets that a display transmitter sends during vertical blanking. Each packet is nine 32-bit words: one header word and eight payload words. Every packet exists in two copies. Software fills the staged copy through a small register port. The transmitter reads only the active copy.

Software picks a starting word through an index register. It then pushes words through a data register, and the index steps forward by one after each write. When a packet is complete, software sets that packet's bit in an arm register. At the next frame update pulse that arrives while the update lock is low, every armed packet's staged words are copied into its active copy, and the arm bit clears itself. A sticky status flag records any data write that lands on the slot the transmitter is reading in that same cycle. Software clears the flag by writing a 1 to a separate bit.

Top module: `ipkt_store`

## Requirements
- R1: After reset the index, the arm bits, the conflict flag and `hw_rd_data` are all zero, and every staged and active word reads as zero.
- R2: A write to register 0 (INDEX) loads bits 7:0 as the word index only when the written value is below 135. Larger values are ignored. A read of register 0 returns the current index.
- R3: A write to register 1 (DATA) stores the word at the current index, and the index then increases by one. Slot s, word w lives at index 9*s+w. Word 0 is the header, with header byte 0 in bits 7:0 up to byte 3 in bits 31:24. A read of register 1 returns the staged word at the current index.
- R4: While the index equals 135, a DATA write changes no stored word and the index stays at 135. A DATA read there returns zero.
- R5: A write to register 2 (ARM) ORs bits 14:0 into the pending mask, so bit k arms slot k and zeros have no effect. A read of register 2 returns the pending mask.
- R6: At a `frame_pulse` cycle with `update_lock` low, every pending slot's nine staged words are copied to its active copy. The pending bits of those slots read 0 from the next cycle.
- R7: At a `frame_pulse` cycle with `update_lock` high, no active word and no pending bit changes.
- R8: Staged writes never reach the active copy without a commit. A commit leaves slots that are not armed unchanged.
- R9: With `hw_rd_en` high, `hw_rd_data` shows the active word at (`hw_rd_slot`, `hw_rd_word`) one cycle later. A slot of 15 or more, or a word of 9 or more, returns zero. With `hw_rd_en` low, `hw_rd_data` holds its value.
- R10: A DATA write whose slot (index/9) equals `hw_rd_slot` while `hw_rd_en` is high sets bit 0 of register 3 (STATUS). The bit stays set until a write to register 3 with bit 1 set clears it.
- R11: An ARM write in the same cycle as a committing pulse leaves its bits pending for the next pulse. A slot that was already pending still commits in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 INDEX, 1 DATA, 2 ARM, 3 STATUS |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| frame_pulse | input | 1 | Frame update pulse |
| update_lock | input | 1 | Blocks commits while high |
| hw_rd_en | input | 1 | Transmitter read request |
| hw_rd_slot | input | 4 | Slot to read |
| hw_rd_word | input | 4 | Word within the slot |
| hw_rd_data | output | 32 | Active word, one cycle after the request |

## Verification
Two functions can fall in the same cycle and must be checked together.

The first pair is a software write through the data register and a transmitter read. The bench drives the register write and the hardware read on the same clock edge. It then checks three things:
- the conflict bit in STATUS is set when the two slots match, and stays clear when they differ;
- the transmitter still receives the old active word through the scoreboard queue;
- the staged word is updated.

The second pair is an arm write and a committing frame pulse. The bench issues them in the same cycle. It then confirms that the newly armed slot stays pending and keeps its old active contents, while the slot that was already pending commits.

// File: rtl/ipkt_pkg.sv
package ipkt_pkg;

    // Default geometry of the store
    localparam int NUM_SLOTS      = 15;
    localparam int WORDS_PER_SLOT = 9;
    localparam int DATA_W         = 32;

    // Register selector on the programming port
    typedef enum logic [1:0] {
        SEL_INDEX  = 2'd0,
        SEL_DATA   = 2'd1,
        SEL_ARM    = 2'd2,
        SEL_STATUS = 2'd3
    } reg_sel_e;

    // Bit of the STATUS write that clears the conflict flag
    localparam int STATUS_CLR_BIT = 1;

    // Write target derived from the running index
    typedef struct packed {
        logic       en;
        logic [3:0] slot;
        logic [3:0] word;
    } stage_wr_t;

endpackage

// File: rtl/ipkt_slot.sv
module ipkt_slot #(
    parameter int WORDS  = ipkt_pkg::WORDS_PER_SLOT,
    parameter int DATA_W = ipkt_pkg::DATA_W,
    parameter int WORD_W = $clog2(WORDS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [WORD_W-1:0]            wr_word,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         commit,
    output logic [WORDS-1:0][DATA_W-1:0] staged_o,
    output logic [WORDS-1:0][DATA_W-1:0] active_o
);

    // The commit copies the staged words as they were before this edge's write
    always_ff @(posedge clk) begin
        if (rst) begin
            staged_o <= '0;
            active_o <= '0;
        end else begin
            if (commit) begin
                active_o <= staged_o;
            end
            if (wr_en) begin
                staged_o[wr_word] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/ipkt_regif.sv
module ipkt_regif
    import ipkt_pkg::*;
#(
    parameter int NUM_SLOTS = ipkt_pkg::NUM_SLOTS,
    parameter int WORDS     = ipkt_pkg::WORDS_PER_SLOT,
    parameter int DATA_W    = ipkt_pkg::DATA_W,
    parameter int TOTAL     = NUM_SLOTS * WORDS,
    parameter int IDX_W     = $clog2(TOTAL + 1),
    parameter int SLOT_W    = $clog2(NUM_SLOTS),
    parameter int WORD_W    = $clog2(WORDS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_we,
    input  reg_sel_e             reg_sel,
    input  logic [DATA_W-1:0]    reg_wdata,
    input  logic                 frame_pulse,
    input  logic                 update_lock,
    input  logic                 hw_rd_en,
    input  logic [SLOT_W-1:0]    hw_rd_slot,
    output logic [IDX_W-1:0]     idx_o,
    output logic                 idx_valid_o,
    output logic                 wr_en_o,
    output logic [SLOT_W-1:0]    wr_slot_o,
    output logic [WORD_W-1:0]    wr_word_o,
    output logic [NUM_SLOTS-1:0] commit_o,
    output logic [NUM_SLOTS-1:0] pending_o,
    output logic                 conflict_o
);

    logic [IDX_W-1:0]     idx_q;
    logic [NUM_SLOTS-1:0] pending_q;
    logic                 conflict_q;
    logic                 idx_load;
    logic                 arm_wr;
    logic                 clr_wr;
    logic                 fire;
    logic                 collide;

    assign idx_valid_o = (idx_q < IDX_W'(TOTAL));
    assign wr_slot_o   = SLOT_W'(idx_q / IDX_W'(WORDS));
    assign wr_word_o   = WORD_W'(idx_q % IDX_W'(WORDS));
    assign wr_en_o     = reg_we && (reg_sel == SEL_DATA) && idx_valid_o;

    assign idx_load = reg_we && (reg_sel == SEL_INDEX) && (reg_wdata < DATA_W'(TOTAL));
    assign arm_wr   = reg_we && (reg_sel == SEL_ARM);
    assign clr_wr   = reg_we && (reg_sel == SEL_STATUS) && reg_wdata[STATUS_CLR_BIT];
    assign fire     = frame_pulse && !update_lock;
    assign commit_o = fire ? pending_q : '0;
    assign collide  = wr_en_o && hw_rd_en && (wr_slot_o == hw_rd_slot);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q      <= '0;
            pending_q  <= '0;
            conflict_q <= 1'b0;
        end else begin
            if (idx_load) begin
                idx_q <= IDX_W'(reg_wdata);
            end else if (wr_en_o) begin
                idx_q <= idx_q + IDX_W'(1);
            end
            pending_q <= (pending_q & ~commit_o)
                       | (arm_wr ? reg_wdata[NUM_SLOTS-1:0] : '0);
            if (collide) begin
                conflict_q <= 1'b1;
            end else if (clr_wr) begin
                conflict_q <= 1'b0;
            end
        end
    end

    assign idx_o      = idx_q;
    assign pending_o  = pending_q;
    assign conflict_o = conflict_q;

endmodule

// File: rtl/ipkt_rdport.sv
module ipkt_rdport #(
    parameter int NUM_SLOTS = ipkt_pkg::NUM_SLOTS,
    parameter int WORDS     = ipkt_pkg::WORDS_PER_SLOT,
    parameter int DATA_W    = ipkt_pkg::DATA_W,
    parameter int SLOT_W    = $clog2(NUM_SLOTS),
    parameter int WORD_W    = $clog2(WORDS)
) (
    input  logic                                        clk,
    input  logic                                        rst,
    input  logic                                        en,
    input  logic [SLOT_W-1:0]                           slot,
    input  logic [WORD_W-1:0]                           word,
    input  logic [NUM_SLOTS-1:0][WORDS-1:0][DATA_W-1:0] active_i,
    output logic [DATA_W-1:0]                           data_o
);

    logic [DATA_W-1:0] pick;

    always_comb begin
        pick = '0;
        if ((32'(slot) < NUM_SLOTS) && (32'(word) < WORDS)) begin
            pick = active_i[slot][word];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_o <= '0;
        end else if (en) begin
            data_o <= pick;
        end
    end

endmodule

// File: rtl/ipkt_store.sv
module ipkt_store
    import ipkt_pkg::*;
#(
    parameter int NUM_SLOTS      = ipkt_pkg::NUM_SLOTS,
    parameter int WORDS_PER_SLOT = ipkt_pkg::WORDS_PER_SLOT,
    parameter int DATA_W         = ipkt_pkg::DATA_W
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              reg_we,
    input  logic [1:0]                        reg_addr,
    input  logic [DATA_W-1:0]                 reg_wdata,
    output logic [DATA_W-1:0]                 reg_rdata,
    input  logic                              frame_pulse,
    input  logic                              update_lock,
    input  logic                              hw_rd_en,
    input  logic [$clog2(NUM_SLOTS)-1:0]      hw_rd_slot,
    input  logic [$clog2(WORDS_PER_SLOT)-1:0] hw_rd_word,
    output logic [DATA_W-1:0]                 hw_rd_data
);

    localparam int TOTAL  = NUM_SLOTS * WORDS_PER_SLOT;
    localparam int IDX_W  = $clog2(TOTAL + 1);
    localparam int SLOT_W = $clog2(NUM_SLOTS);
    localparam int WORD_W = $clog2(WORDS_PER_SLOT);

    reg_sel_e                                            reg_sel;
    logic [IDX_W-1:0]                                    idx;
    logic                                                idx_valid;
    stage_wr_t                                           stw;
    logic [NUM_SLOTS-1:0]                                commit;
    logic [NUM_SLOTS-1:0]                                pending;
    logic                                                conflict;
    logic [NUM_SLOTS-1:0][WORDS_PER_SLOT-1:0][DATA_W-1:0] staged_all;
    logic [NUM_SLOTS-1:0][WORDS_PER_SLOT-1:0][DATA_W-1:0] active_all;
    logic [SLOT_W-1:0]                                   wr_slot;
    logic [WORD_W-1:0]                                   wr_word;
    logic                                                wr_en;

    assign reg_sel = reg_sel_e'(reg_addr);

    ipkt_regif #(
        .NUM_SLOTS (NUM_SLOTS),
        .WORDS     (WORDS_PER_SLOT),
        .DATA_W    (DATA_W)
    ) u_regif (
        .clk         (clk),
        .rst         (rst),
        .reg_we      (reg_we),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .frame_pulse (frame_pulse),
        .update_lock (update_lock),
        .hw_rd_en    (hw_rd_en),
        .hw_rd_slot  (hw_rd_slot),
        .idx_o       (idx),
        .idx_valid_o (idx_valid),
        .wr_en_o     (wr_en),
        .wr_slot_o   (wr_slot),
        .wr_word_o   (wr_word),
        .commit_o    (commit),
        .pending_o   (pending),
        .conflict_o  (conflict)
    );

    assign stw.en   = wr_en;
    assign stw.slot = 4'(wr_slot);
    assign stw.word = 4'(wr_word);

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        ipkt_slot #(
            .WORDS  (WORDS_PER_SLOT),
            .DATA_W (DATA_W)
        ) u_slot (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (stw.en && (stw.slot == 4'(s))),
            .wr_word  (WORD_W'(stw.word)),
            .wr_data  (reg_wdata),
            .commit   (commit[s]),
            .staged_o (staged_all[s]),
            .active_o (active_all[s])
        );
    end

    ipkt_rdport #(
        .NUM_SLOTS (NUM_SLOTS),
        .WORDS     (WORDS_PER_SLOT),
        .DATA_W    (DATA_W)
    ) u_rdport (
        .clk      (clk),
        .rst      (rst),
        .en       (hw_rd_en),
        .slot     (hw_rd_slot),
        .word     (hw_rd_word),
        .active_i (active_all),
        .data_o   (hw_rd_data)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_INDEX:  reg_rdata = DATA_W'(idx);
            SEL_DATA:   if (idx_valid) reg_rdata = staged_all[wr_slot][wr_word];
            SEL_ARM:    reg_rdata = DATA_W'(pending);
            SEL_STATUS: reg_rdata = DATA_W'(conflict);
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ipkt_store_chk.sv
module ipkt_store_chk #(
    parameter int NUM_SLOTS = 15,
    parameter int WORDS     = 9,
    parameter int DATA_W    = 32,
    parameter int TOTAL     = NUM_SLOTS * WORDS,
    parameter int IDX_W     = $clog2(TOTAL + 1),
    parameter int SLOT_W    = $clog2(NUM_SLOTS),
    parameter int WORD_W    = $clog2(WORDS)
) (
    input logic                                        clk,
    input logic                                        rst,
    input logic                                        reg_we,
    input logic [1:0]                                  reg_addr,
    input logic [DATA_W-1:0]                           reg_wdata,
    input logic                                        frame_pulse,
    input logic                                        update_lock,
    input logic                                        hw_rd_en,
    input logic [SLOT_W-1:0]                           hw_rd_slot,
    input logic [WORD_W-1:0]                           hw_rd_word,
    input logic [DATA_W-1:0]                           hw_rd_data,
    input logic [IDX_W-1:0]                            idx,
    input logic                                        wr_en,
    input logic [SLOT_W-1:0]                           wr_slot,
    input logic [NUM_SLOTS-1:0]                        pending,
    input logic                                        conflict,
    input logic [NUM_SLOTS-1:0][WORDS-1:0][DATA_W-1:0] active_all
);

    logic              arm_wr;
    logic              clr_wr;
    logic              in_range;
    logic [DATA_W-1:0] sel_word;

    assign arm_wr   = reg_we && (reg_addr == 2'd2);
    assign clr_wr   = reg_we && (reg_addr == 2'd3) && reg_wdata[1];
    assign in_range = (32'(hw_rd_slot) < NUM_SLOTS) && (32'(hw_rd_word) < WORDS);

    always_comb begin
        sel_word = '0;
        if (in_range) sel_word = active_all[hw_rd_slot][hw_rd_word];
    end

    assert_index_bound_R4: assert property (@(posedge clk) disable iff (rst)
        32'(idx) <= TOTAL);

    assert_index_stuck_R4: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == 2'd1 && 32'(idx) == TOTAL) |=> (32'(idx) == TOTAL));

    assert_commit_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (frame_pulse && !update_lock && !arm_wr) |=> (pending == '0));

    assert_lock_active_R7: assert property (@(posedge clk) disable iff (rst)
        !(frame_pulse && !update_lock) |=> $stable(active_all));

    assert_lock_pending_R7: assert property (@(posedge clk) disable iff (rst)
        (update_lock && !arm_wr) |=> $stable(pending));

    assert_rd_latency_R9: assert property (@(posedge clk) disable iff (rst)
        hw_rd_en |=> (hw_rd_data == $past(sel_word)));

    assert_rd_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !hw_rd_en |=> $stable(hw_rd_data));

    assert_conflict_set_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && hw_rd_en && wr_slot == hw_rd_slot) |=> conflict);

    assert_conflict_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (conflict && !clr_wr) |=> conflict);

endmodule

bind ipkt_store ipkt_store_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .WORDS     (WORDS_PER_SLOT),
    .DATA_W    (DATA_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .frame_pulse (frame_pulse),
    .update_lock (update_lock),
    .hw_rd_en    (hw_rd_en),
    .hw_rd_slot  (hw_rd_slot),
    .hw_rd_word  (hw_rd_word),
    .hw_rd_data  (hw_rd_data),
    .idx         (idx),
    .wr_en       (wr_en),
    .wr_slot     (wr_slot),
    .pending     (pending),
    .conflict    (conflict),
    .active_all  (active_all)
);

// File: tb/ipkt_store_bench.sv
`timescale 1ns/1ps
module ipkt_store_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        frame_pulse;
    logic        update_lock;
    logic        hw_rd_en;
    logic [3:0]  hw_rd_slot;
    logic [3:0]  hw_rd_word;
    logic [31:0] hw_rd_data;

    always #4 clk = ~clk;

    ipkt_store u_ipkt_store (
        .clk         (clk),
        .rst         (rst),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .frame_pulse (frame_pulse),
        .update_lock (update_lock),
        .hw_rd_en    (hw_rd_en),
        .hw_rd_slot  (hw_rd_slot),
        .hw_rd_word  (hw_rd_word),
        .hw_rd_data  (hw_rd_data)
    );

    int  checks   = 0;
    int  failures = 0;
    bit  finished = 0;

    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic [31:0] stg_m [135];
    logic [31:0] act_m [135];
    logic [14:0] pend_m;
    logic        issued;
    logic [31:0] rd;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] act_exp(int s, int w);
        if (s < 15 && w < 9) return act_m[s*9+w];
        return 32'h0;
    endfunction

    // driver: issue a transmitter read and queue its expected result
    task automatic hw_read(int s, int w, string tag);
        @(negedge clk);
        hw_rd_en = 1'b1; hw_rd_slot = 4'(s); hw_rd_word = 4'(w);
        exp_q.push_back(act_exp(s, w));
        tag_q.push_back(tag);
        @(negedge clk);
        hw_rd_en = 1'b0;
    endtask

    task automatic load_packet(int s, logic [31:0] seed);
        reg_wr(2'd0, 32'(s*9));
        for (int i = 0; i < 9; i++) begin
            logic [31:0] w;
            w = seed + 32'(i) * 32'h0101_0101;
            reg_wr(2'd1, w);
            stg_m[s*9+i] = w;
        end
    endtask

    task automatic model_commit(logic [14:0] arm_now);
        for (int s = 0; s < 15; s++)
            if (pend_m[s]) for (int i = 0; i < 9; i++) act_m[s*9+i] = stg_m[s*9+i];
        pend_m = arm_now;
    endtask

    task automatic pulse(logic lock);
        @(negedge clk);
        frame_pulse = 1'b1; update_lock = lock;
        @(negedge clk);
        frame_pulse = 1'b0; update_lock = 1'b0;
        if (!lock) model_commit(15'h0);
    endtask

    // monitor: compare transmitter data against the queue
    always @(posedge clk) issued <= rst ? 1'b0 : hw_rd_en;

    always @(negedge clk) begin
        if (issued) begin
            if (exp_q.size() == 0) chk("R9 unexpected read", hw_rd_data, 32'hx);
            else chk(tag_q.pop_front(), hw_rd_data, exp_q.pop_front());
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; reg_we = 0; reg_addr = 0; reg_wdata = 0;
        frame_pulse = 0; update_lock = 0; hw_rd_en = 0; hw_rd_slot = 0; hw_rd_word = 0;
        for (int i = 0; i < 135; i++) begin stg_m[i] = 0; act_m[i] = 0; end
        pend_m = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            reg_rd(2'(a), rd);
            chk("R1 reset register", rd, 32'h0);
        end
        chk("R1 reset hw_rd_data", hw_rd_data, 32'h0);
        hw_read(7, 4, "R1 active zero");

        // R2 index load and ignore
        reg_wr(2'd0, 32'd27);
        reg_rd(2'd0, rd); chk("R2 index load", rd, 32'd27);
        reg_wr(2'd0, 32'd135);
        reg_rd(2'd0, rd); chk("R2 index 135 ignored", rd, 32'd27);
        reg_wr(2'd0, 32'h0000_0100);
        reg_rd(2'd0, rd); chk("R2 index 256 ignored", rd, 32'd27);

        // R3 packet write through auto-stepping index
        load_packet(3, 32'h4433_2211);
        reg_rd(2'd0, rd); chk("R3 index stepped", rd, 32'd36);
        reg_wr(2'd0, 32'd27);
        reg_rd(2'd1, rd); chk("R3 header word", rd, 32'h4433_2211);
        chk("R3 header byte0 in 7:0", {24'h0, rd[7:0]}, 32'h11);
        reg_wr(2'd0, 32'd35);
        reg_rd(2'd1, rd); chk("R3 last payload", rd, stg_m[35]);

        // R8 staged data not visible before commit
        hw_read(3, 0, "R8 no commit yet");

        // R5 arm OR semantics
        reg_wr(2'd2, 32'h0000_0008); pend_m = 15'h0008;
        reg_rd(2'd2, rd); chk("R5 arm set", rd, 32'h8);
        reg_wr(2'd2, 32'h0);
        reg_rd(2'd2, rd); chk("R5 zero no effect", rd, 32'h8);

        // R7 locked pulse
        pulse(1'b1);
        reg_rd(2'd2, rd); chk("R7 pending kept", rd, 32'h8);
        hw_read(3, 0, "R7 active unchanged");

        // R6 commit
        pulse(1'b0);
        reg_rd(2'd2, rd); chk("R6 pending cleared", rd, 32'h0);
        for (int w = 0; w < 9; w++) hw_read(3, w, "R6 committed word");

        // R11 arm write in the committing cycle
        load_packet(5, 32'hA0B0_C0D0);
        reg_wr(2'd2, 32'h0000_0020); pend_m = 15'h0020;
        load_packet(3, 32'h1357_9BDF);
        @(negedge clk);
        frame_pulse = 1'b1; reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 32'h0000_0008;
        @(negedge clk);
        frame_pulse = 1'b0; reg_we = 1'b0;
        model_commit(15'h0008);
        reg_rd(2'd2, rd); chk("R11 new arm pending", rd, 32'h8);
        hw_read(5, 2, "R11 pending slot committed");
        hw_read(3, 1, "R11 late arm not committed");
        hw_read(0, 0, "R8 unarmed slot untouched");
        pulse(1'b0);
        hw_read(3, 1, "R11 committed next pulse");

        // R4 writes past the end
        load_packet(14, 32'h0F1E_2D3C);
        reg_rd(2'd0, rd); chk("R4 index at end", rd, 32'd135);
        reg_wr(2'd1, 32'hDEAD_BEEF);
        reg_rd(2'd0, rd); chk("R4 index stays", rd, 32'd135);
        reg_rd(2'd1, rd); chk("R4 data read past end", rd, 32'h0);
        reg_wr(2'd2, 32'h0000_4000); pend_m = 15'h4000;
        pulse(1'b0);
        hw_read(14, 8, "R4 last word not clobbered");

        // R9 out of range and hold
        hw_read(15, 0, "R9 slot out of range");
        hw_read(14, 0, "R9 in range");
        hw_read(2, 9, "R9 word out of range");
        repeat (3) @(negedge clk);
        chk("R9 hold without enable", hw_rd_data, 32'h0);

        // R10 conflict: data write and transmitter read in the same cycle
        reg_rd(2'd3, rd); chk("R10 status clear", rd, 32'h0);
        reg_wr(2'd0, 32'd18);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h5555_AAAA;
        hw_rd_en = 1'b1; hw_rd_slot = 4'd2; hw_rd_word = 4'd0;
        exp_q.push_back(act_exp(2, 0)); tag_q.push_back("R10 read sees old active");
        stg_m[18] = 32'h5555_AAAA;
        @(negedge clk);
        reg_we = 1'b0; hw_rd_en = 1'b0;
        reg_rd(2'd3, rd); chk("R10 conflict set", rd, 32'h1);
        reg_wr(2'd0, 32'd18);
        reg_rd(2'd1, rd); chk("R10 staged write landed", rd, 32'h5555_AAAA);
        reg_wr(2'd3, 32'h0000_0001);
        reg_rd(2'd3, rd); chk("R10 sticky without clear bit", rd, 32'h1);
        reg_wr(2'd3, 32'h0000_0002);
        reg_rd(2'd3, rd); chk("R10 cleared", rd, 32'h0);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h0;
        hw_rd_en = 1'b1; hw_rd_slot = 4'd4; hw_rd_word = 4'd0;
        exp_q.push_back(act_exp(4, 0)); tag_q.push_back("R10 other slot read");
        @(negedge clk);
        reg_we = 1'b0; hw_rd_en = 1'b0;
        reg_rd(2'd3, rd); chk("R10 no conflict other slot", rd, 32'h0);

        repeat (4) @(negedge clk);
        chk("R9 queue drained", 32'(exp_q.size()), 32'h0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule